// File: doc/BRIEF.md
# Random Word Conditioner

The block turns a stream of raw entropy bits into 32-bit random words. Each raw bit arrives with a one-cycle strobe. The bit is accepted only while the noise-enable control is high. It then passes through a conditioning path chosen by a two-bit selector: a straight path, a 32-bit LFSR scrambler, a pair-based bias corrector (whitener), or the scrambler followed by the whitener. Conditioned bits are packed into a word. When a full word is ready, it is latched into a holding register and a valid flag is raised in a status word.

Software polls the status word and then reads the data word. Reading the data word consumes it: the flag clears and packing starts again from an empty word. A test-mode control swaps the external noise for an internal 16-bit LFSR, so the output sequence is repeatable after reset and can be checked against known values. Changing the selector discards any partly built word and any half-collected whitener pair.

Top module: `rng_post_unit`

## Requirements
- R1: After reset the status word reads 0 and the data word reads 0.
- R2: A raw strobe with noiseEn low has no effect. No bit is packed, no source or scrambler state advances, and the status stays unchanged.
- R3: With ctrlSel=0 the accepted bits are packed unchanged. Bit k of the word is the k-th packed bit (LSB first). On the 32nd packed bit the word is latched and status bit 0 (valid) reads 1.
- R4: With ctrlSel=1, each accepted bit b produces the output e = s[0] XOR b from the 32-bit scrambler state s. The state then becomes (s>>1) XOR (e ? 0x80200003 : 0). The reset value of s is 0x00000001, and s advances only on accepted bits while ctrlSel bit 0 is 1.
- R5: With ctrlSel=2, the bits are taken in pairs (first, second). The pair 10 emits 1 and the pair 01 emits 0; pairs 00 and 11 emit nothing.
- R6: With ctrlSel=3, the scrambler output of R4 feeds the whitener of R5.
- R7: With testMode high, the source bit is t[0] of a 16-bit state t and rawBit is ignored. t resets to 0xACE1. On each accepted strobe t becomes (t>>1) XOR (t[0] ? 0xB400 : 0).
- R8: A read with rdEn=1 and rdAddr=0 returns the data word. It then clears valid and restarts packing from zero bits; the bit strobed in that cycle is dropped unless it completes a word (R12).
- R9: A read with rdAddr=1 returns {31'b0, valid} and changes nothing.
- R10: If valid is 1 when a new word completes (with no data read in that cycle), the new word is dropped and the held word is kept.
- R11: A change of ctrlSel from its previous cycle's value clears the partial word and the pending whitener half-pair. The packed bit of that cycle is discarded.
- R12: A word that completes in the same cycle as a data read is stored and valid stays 1; the read itself returns the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlSel | input | 2 | Conditioning path select: 0 raw, 1 scrambler, 2 whitener, 3 scrambler then whitener |
| noiseEn | input | 1 | Accept raw bits when high |
| testMode | input | 1 | Use internal deterministic source instead of rawBit |
| rawBit | input | 1 | Raw entropy bit |
| rawStrobe | input | 1 | Raw bit qualifier, one cycle per bit |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 1 | Register select: 0 data word, 1 status word |
| rdData | output | 32 | Read data for the selected register |

## Verification
A data read can fall in the same cycle as the strobe that completes a word, while the held word is still valid. This is the case where consuming and refilling collide. The bench drives 31 bits, raises rdEn with rdAddr=0 together with the 32nd strobe, and checks during that cycle that the old word is returned. After the edge it checks that valid is still set and that the new word is held. The bench also covers the other side of the same rule: a completed word with no read is dropped while valid is high.

// File: rtl/rngpp_pkg.sv
package rngpp_pkg;

  typedef enum logic [1:0] {
    PP_RAW   = 2'd0,
    PP_SCR   = 2'd1,
    PP_WHITE = 2'd2,
    PP_BOTH  = 2'd3
  } ppSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // raw bit taken this cycle
    logic flush;    // selector changed: drop partial word and half pair
    logic restart;  // packing restarts from zero bits
    logic storeOk;  // a completed word may be latched
  } rngCtl_t;

endpackage

// File: rtl/rngpp_whitener.sv
module rngpp_whitener (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inBit,
  input  logic flush,
  output logic outValid,
  output logic outBit
);

  logic hasHalf;
  logic halfBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hasHalf <= 1'b0;
      halfBit <= 1'b0;
    end else if (flush) begin
      hasHalf <= 1'b0;
    end else if (inValid) begin
      if (hasHalf) begin
        hasHalf <= 1'b0;
      end else begin
        hasHalf <= 1'b1;
        halfBit <= inBit;
      end
    end
  end

  // unequal pair: the first bit of the pair is the result
  assign outValid = inValid & hasHalf & (halfBit ^ inBit) & ~flush;
  assign outBit   = halfBit;

endmodule

// File: rtl/rngpp_ctrl.sv
module rngpp_ctrl
  import rngpp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ctrlSel,
  input  logic       noiseEn,
  input  logic       rawStrobe,
  input  logic       rdEn,
  input  logic       rdAddr,
  input  logic       wordLoaded,
  output rngCtl_t    ctl,
  output logic       validFlag
);

  logic [1:0] selPrev;
  logic       validQ;
  logic       readData;

  assign readData = rdEn & ~rdAddr;

  always_comb begin
    ctl.accept  = rawStrobe & noiseEn;
    ctl.flush   = (ctrlSel != selPrev);
    ctl.restart = (ctrlSel != selPrev) | readData;
    ctl.storeOk = ~validQ | readData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 2'd0;
      validQ  <= 1'b0;
    end else begin
      selPrev <= ctrlSel;
      if (wordLoaded) begin
        validQ <= 1'b1;
      end else if (readData) begin
        validQ <= 1'b0;
      end
    end
  end

  assign validFlag = validQ;

endmodule

// File: rtl/rngpp_datapath.sv
module rngpp_datapath
  import rngpp_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter logic [31:0]     SCR_POLY = 32'h8020_0003,
  parameter logic [31:0]     SCR_SEED = 32'h0000_0001,
  parameter int              TST_W    = 16,
  parameter logic [15:0]     TST_SEED = 16'hACE1,
  parameter logic [15:0]     TST_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  rngCtl_t           ctl,
  input  logic [1:0]        ctrlSel,
  input  logic              testMode,
  input  logic              rawBit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordLoaded
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  ppSel_t selMode;
  logic   useScr;
  logic   useWhite;

  logic [TST_W-1:0]  tstQ;
  logic [WORD_W-1:0] scrQ;
  logic [WORD_W-1:0] asmQ;
  logic [WORD_W-1:0] wordQ;
  logic [CNT_W-1:0]  cntQ;

  logic srcBit;
  logic scrBit;
  logic stageBit;
  logic whValid;
  logic whBit;
  logic packValid;
  logic packBit;
  logic lastBit;
  logic [WORD_W-1:0] fullWord;

  assign selMode  = ppSel_t'(ctrlSel);
  assign useScr   = (selMode == PP_SCR) || (selMode == PP_BOTH);
  assign useWhite = (selMode == PP_WHITE) || (selMode == PP_BOTH);

  // source and first stage
  assign srcBit   = testMode ? tstQ[0] : rawBit;
  assign scrBit   = scrQ[0] ^ srcBit;
  assign stageBit = useScr ? scrBit : srcBit;

  rngpp_whitener u_white (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (ctl.accept & useWhite),
    .inBit    (stageBit),
    .flush    (ctl.flush),
    .outValid (whValid),
    .outBit   (whBit)
  );

  assign packValid  = ~ctl.flush & (useWhite ? whValid : ctl.accept);
  assign packBit    = useWhite ? whBit : stageBit;
  assign lastBit    = (cntQ == LAST_IDX);
  assign fullWord   = {packBit, asmQ[WORD_W-1:1]};
  assign wordLoaded = packValid & lastBit & ctl.storeOk;

  // deterministic test source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tstQ <= TST_SEED[TST_W-1:0];
    end else if (ctl.accept && testMode) begin
      tstQ <= (tstQ >> 1) ^ ({TST_W{tstQ[0]}} & TST_TAPS[TST_W-1:0]);
    end
  end

  // scrambler state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrQ <= SCR_SEED[WORD_W-1:0];
    end else if (ctl.accept && useScr) begin
      scrQ <= (scrQ >> 1) ^ ({WORD_W{scrBit}} & SCR_POLY[WORD_W-1:0]);
    end
  end

  // packer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      asmQ <= '0;
    end else if (ctl.restart) begin
      cntQ <= '0;
      asmQ <= '0;
    end else if (packValid) begin
      asmQ <= fullWord;
      cntQ <= lastBit ? '0 : cntQ + 1'b1;
    end
  end

  // holding word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (wordLoaded) begin
      wordQ <= fullWord;
    end
  end

  assign wordOut = wordQ;

endmodule

// File: rtl/rng_post_unit.sv
module rng_post_unit
  import rngpp_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter logic [31:0] SCR_POLY = 32'h8020_0003,
  parameter logic [31:0] SCR_SEED = 32'h0000_0001,
  parameter int          TST_W    = 16,
  parameter logic [15:0] TST_SEED = 16'hACE1,
  parameter logic [15:0] TST_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ctrlSel,
  input  logic              noiseEn,
  input  logic              testMode,
  input  logic              rawBit,
  input  logic              rawStrobe,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [WORD_W-1:0] rdData
);

  rngCtl_t           ctl;
  logic              validFlag;
  logic              wordLoaded;
  logic [WORD_W-1:0] wordOut;

  rngpp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlSel    (ctrlSel),
    .noiseEn    (noiseEn),
    .rawStrobe  (rawStrobe),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .wordLoaded (wordLoaded),
    .ctl        (ctl),
    .validFlag  (validFlag)
  );

  rngpp_datapath #(
    .WORD_W   (WORD_W),
    .SCR_POLY (SCR_POLY),
    .SCR_SEED (SCR_SEED),
    .TST_W    (TST_W),
    .TST_SEED (TST_SEED),
    .TST_TAPS (TST_TAPS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .ctrlSel    (ctrlSel),
    .testMode   (testMode),
    .rawBit     (rawBit),
    .wordOut    (wordOut),
    .wordLoaded (wordLoaded)
  );

  assign rdData = rdAddr ? {{(WORD_W-1){1'b0}}, validFlag} : wordOut;

endmodule

// File: rtl/rngpp_checker.sv
module rngpp_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              noiseEn,
  input logic              rawStrobe,
  input logic              rdEn,
  input logic              rdAddr,
  input logic              validFlag,
  input logic              wordLoaded,
  input logic              ctlFlush,
  input logic [WORD_W-1:0] wordQ
);

  // R2: without an accepted strobe no word can become valid
  p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rawStrobe && noiseEn) |=> !$rose(validFlag));

  // R3: valid only rises after a word was latched
  p_valid_from_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validFlag) |-> $past(wordLoaded));

  // R8: data read without a completing word leaves valid clear
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr && !wordLoaded) |=> !validFlag);

  // R9: status read keeps valid
  p_status_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr && validFlag) |=> validFlag);

  // R10: held word stays while valid and not read
  p_keep_old_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validFlag && !(rdEn && !rdAddr)) |=> $stable(wordQ));

  // R11: a selector change never completes a word
  p_flush_no_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctlFlush |-> !wordLoaded);

  // R12: refill in the read cycle keeps valid set
  p_coincide_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr && wordLoaded) |=> validFlag);

endmodule

bind rng_post_unit rngpp_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .noiseEn    (noiseEn),
  .rawStrobe  (rawStrobe),
  .rdEn       (rdEn),
  .rdAddr     (rdAddr),
  .validFlag  (validFlag),
  .wordLoaded (wordLoaded),
  .ctlFlush   (ctl.flush),
  .wordQ      (wordOut)
);

// File: tb/rng_post_unit_test.sv
module rng_post_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  ctrlSel = 2'd0;
  logic        noiseEn = 1'b0;
  logic        testMode = 1'b0;
  logic        rawBit = 1'b0;
  logic        rawStrobe = 1'b0;
  logic        rdEn = 1'b0;
  logic        rdAddr = 1'b0;
  logic [31:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench-side expected state, from the requirements
  logic [15:0] mTst;
  logic [31:0] mScr;
  logic        mHas;
  logic        mHalf;
  int          mCnt;
  logic [31:0] mAsm;
  logic [31:0] mWord;
  logic        mValid;
  logic [1:0]  mSelPrev;

  always #2 clk = ~clk;

  rng_post_unit uut (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlSel   (ctrlSel),
    .noiseEn   (noiseEn),
    .testMode  (testMode),
    .rawBit    (rawBit),
    .rawStrobe (rawStrobe),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mTst = 16'hACE1; mScr = 32'h1; mHas = 0; mHalf = 0;
    mCnt = 0; mAsm = 0; mWord = 0; mValid = 0; mSelPrev = 0;
  endtask

  task automatic modelStep(input logic acc, input logic b, input logic rd);
    logic flush, src, s1, pv, pb, done;
    flush = (ctrlSel != mSelPrev);
    mSelPrev = ctrlSel;
    pv = 0; pb = 0;
    if (acc) begin
      src = b;
      if (testMode) begin
        src = mTst[0];
        mTst = (mTst >> 1) ^ (mTst[0] ? 16'hB400 : 16'h0);
      end
      s1 = src;
      if (ctrlSel[0]) begin
        s1 = mScr[0] ^ src;
        mScr = (mScr >> 1) ^ (s1 ? 32'h8020_0003 : 32'h0);
      end
      if (!flush) begin
        if (ctrlSel[1]) begin
          if (mHas) begin
            mHas = 0;
            if (mHalf != s1) begin pv = 1; pb = mHalf; end
          end else begin
            mHas = 1; mHalf = s1;
          end
        end else begin
          pv = 1; pb = s1;
        end
      end
    end
    if (flush) mHas = 0;
    done = pv && (mCnt == 31);
    if (done && (!mValid || rd)) begin
      mWord = {pb, mAsm[31:1]}; mValid = 1;
    end else if (rd) begin
      mValid = 0;
    end
    if (flush || rd) begin
      mCnt = 0; mAsm = 0;
    end else if (pv) begin
      mAsm = {pb, mAsm[31:1]};
      mCnt = done ? 0 : mCnt + 1;
    end
  endtask

  // one cycle: inputs set after an edge, model updated at the next edge
  task automatic cyc(input logic stb, input logic b, input logic rd);
    rawStrobe = stb; rawBit = b; rdEn = rd; rdAddr = 1'b0;
    @(posedge clk);
    modelStep(stb && noiseEn, b, rd);
    #1;
    rawStrobe = 1'b0; rdEn = 1'b0;
  endtask

  task automatic checkRegs(input string tag);
    rdAddr = 1'b1; #1;
    chk({tag, " status"}, rdData, {31'b0, mValid});
    rdAddr = 1'b0; #1;
    chk({tag, " data"}, rdData, mWord);
  endtask

  task automatic setSel(input logic [1:0] s);
    ctrlSel = s;
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0; ctrlSel = 2'd0; rawStrobe = 0; rdEn = 0;
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    modelReset();
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 0; i < 32; i++) cyc(1'b1, w[i], 1'b0);
  endtask

  task automatic testReset();
    doReset();
    checkRegs("R1 reset");
    chk("R1 data zero", rdData, 32'h0);
  endtask

  task automatic testRaw();
    noiseEn = 1; testMode = 0; setSel(2'd0);
    sendWord(32'hA5C3_1E96);
    chk("R3 raw word", rdData, 32'hA5C3_1E96);
    rdAddr = 1; #1; chk("R3 valid set", rdData, 32'h1); rdAddr = 0;
    cyc(1'b0, 1'b0, 1'b1);
    rdAddr = 1; #1; chk("R8 valid cleared", rdData, 32'h0); rdAddr = 0;
    // partial bits then data read: packing restarts
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    sendWord(32'h0F0F_3355);
    chk("R8 restart from zero", rdData, 32'h0F0F_3355);
    checkRegs("R8 model");
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testDisabled();
    noiseEn = 0;
    for (int i = 0; i < 40; i++) cyc(1'b1, i[0], 1'b0);
    rdAddr = 1; #1; chk("R2 no word while disabled", rdData, 32'h0); rdAddr = 0;
    noiseEn = 1;
    sendWord(32'h1234_5678);
    chk("R2 no partial bits kept", rdData, 32'h1234_5678);
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testScrambler();
    setSel(2'd1);
    sendWord(32'hDEAD_BEEF);
    checkRegs("R4 scrambler");
    // status reads change nothing
    rdEn = 1; rdAddr = 1; @(posedge clk); #1; rdEn = 0;
    rdEn = 1; @(posedge clk); #1; rdEn = 0;
    checkRegs("R9 status read");
    // second word while valid: dropped
    sendWord(32'h0000_FFFF);
    checkRegs("R10 drop");
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testWhite();
    setSel(2'd2);
    for (int i = 0; i < 200; i++) begin
      int t;
      t = (i * 5 + i / 3) % 4;
      cyc(1'b1, t[1], 1'b0);
      cyc(1'b1, t[0], 1'b0);
    end
    checkRegs("R5 whitener");
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testChain();
    setSel(2'd3);
    for (int i = 0; i < 400; i++) cyc(1'b1, ((i * 37 >> 3) ^ i) & 1, 1'b0);
    checkRegs("R6 chain");
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testDeterministic();
    logic [31:0] first;
    doReset();
    noiseEn = 1; testMode = 1;
    for (int i = 0; i < 32; i++) cyc(1'b1, 1'b1, 1'b0);
    checkRegs("R7 test source");
    first = rdData;
    doReset();
    noiseEn = 1; testMode = 1;
    for (int i = 0; i < 32; i++) cyc(1'b1, 1'b0, 1'b0);
    rdAddr = 0; #1;
    chk("R7 repeatable", rdData, first);
    testMode = 0;
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testFlush();
    setSel(2'd0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0);
    setSel(2'd1);
    setSel(2'd0);
    sendWord(32'h8001_7FFE);
    chk("R11 partial word flushed", rdData, 32'h8001_7FFE);
    cyc(1'b0, 1'b0, 1'b1);
    // pending half pair
    setSel(2'd2);
    cyc(1'b1, 1'b1, 1'b0);
    setSel(2'd0);
    setSel(2'd2);
    for (int i = 0; i < 32; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
    end
    chk("R11 half pair flushed", rdData, 32'h0);
    checkRegs("R11 model");
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic testCoincide();
    logic [31:0] oldWord;
    setSel(2'd0);
    sendWord(32'h5555_AAAA);
    oldWord = 32'h5555_AAAA;
    chk("R12 setup", rdData, oldWord);
    for (int i = 0; i < 31; i++) cyc(1'b1, 1'b1, 1'b0);
    rawStrobe = 1; rawBit = 0; rdEn = 1; rdAddr = 0; #1;
    chk("R12 read returns old word", rdData, oldWord);
    @(posedge clk);
    modelStep(1'b1, 1'b0, 1'b1);
    #1; rawStrobe = 0; rdEn = 0;
    rdAddr = 1; #1; chk("R12 valid stays set", rdData, 32'h1); rdAddr = 0; #1;
    chk("R12 new word stored", rdData, 32'h7FFF_FFFF);
    checkRegs("R12 model");
  endtask

  initial begin
    modelReset();
    testReset();
    testRaw();
    testDisabled();
    testScrambler();
    testWhite();
    testChain();
    testDeterministic();
    testFlush();
    testCoincide();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule